// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slow output rate, for example about 32.768 kHz from 24 MHz, when the ratio is not a whole number. It has two integer divisors. A fixed number of output periods is produced with the first divisor, then a fixed number with the second, and the pattern repeats. The average period therefore falls between the two integer ratios. The block can also run on the first divisor alone, or be bypassed so that every reference cycle counts as an output period.

Two control words are written and read back through a small synchronous register port. The output stays in the reference clock domain. It is given two ways: as a one-cycle enable pulse at the start of each output period, and as a divided level with a near-50% duty cycle. Two gates control reconfiguration. The run gate holds the counters in reset. The output gate masks the output, and it switches only between whole periods. Software clears both gates, writes the new ratios, opens the run gate, and opens the output gate later.

Top module: `dmcd_top`

## Requirements
- R1: When `wr_en` is high, `wdata` is written to word 0 (`addr`=0) or word 1 (`addr`=1) on the rising edge. `rdata` gives the word selected by `addr` one cycle later. Reserved bits read as zero, so the readable masks are 0xD0FFFFFF for word 0 and 0x01FFFFFF for word 1.
- R2: A synchronous active-high `rst` sets both words to zero. It also holds `ce_out` and `div_out` low.
- R3: Word 0 fields are: first divisor code in bits 11:0, second divisor code in bits 23:12, dual enable in bit 28, output gate in bit 30 and run gate in bit 31. Word 1 fields are: first repeat code in bits 11:0, second repeat code in bits 23:12 and bypass in bit 24. A code k means divide by k+1 or repeat k+1 times.
- R4: With dual off, every output period is N1+1 reference cycles long. `ce_out` is high for exactly one cycle at the start of each period.
- R5: In each period of length L, `div_out` is high for the first floor(L/2) cycles and low for the rest. When L=1 it never goes high.
- R6: With dual on, the output gives M1+1 periods of length N1+1, then M2+1 periods of length N2+1, and then repeats. With codes 732/731/7/10, one 19-period pattern lasts 13916 reference cycles: 8 periods of 733 cycles followed by 11 periods of 732 cycles.
- R7: With bypass set and both gates open, `ce_out` is high on every cycle and `div_out` stays low, whatever the divisor codes are.
- R8: While the run gate is clear, both outputs stay low. Reopening the run gate starts a new pattern at the first period of the N1 segment.
- R9: While the output gate is effectively closed, both outputs stay low. Opening or closing the output gate takes effect only at a period boundary, so no partial period is ever output.
- R10: Divisor, repeat and dual changes written while running take effect only at the start of the next N1 segment. The period in progress, and the rest of the current pattern, use the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Control word select for write and read |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Registered read data |
| ce_out | output | 1 | One-cycle pulse at the start of each output period |
| div_out | output | 1 | Divided clock level |

## Verification
The hardest states to reach are writes that land partway through a period or partway through a pattern. Examples are a divisor change during the first N1 period, a run-gate drop inside the N2 segment, and output-gate toggles between boundaries. The stimulus first waits for an output pulse so that it is aligned to a known phase. It then issues the write a fixed number of cycles later and compares each following period length against the pattern the requirements predict. Random small divisor and repeat codes, with random dual selection, cover the pattern arithmetic around these directed cases.

// File: rtl/dmcd_pkg.sv
package dmcd_pkg;
  localparam int FLD_W     = 12;
  // control word 0
  localparam int N1_LSB    = 0;
  localparam int N2_LSB    = 12;
  localparam int DUAL_BIT  = 28;
  localparam int OGATE_BIT = 30;
  localparam int IGATE_BIT = 31;
  // control word 1
  localparam int M1_LSB    = 0;
  localparam int M2_LSB    = 12;
  localparam int BYP_BIT   = 24;

  typedef struct packed {
    logic [FLD_W-1:0] n1;
    logic [FLD_W-1:0] n2;
    logic [FLD_W-1:0] m1;
    logic [FLD_W-1:0] m2;
    logic             dual;
    logic             bypass;
    logic             igate;
    logic             ogate;
  } cfg_t;

  typedef struct packed {
    logic [FLD_W-1:0] n1;
    logic [FLD_W-1:0] n2;
    logic [FLD_W-1:0] m1;
    logic [FLD_W-1:0] m2;
    logic             dual;
  } shadow_t;
endpackage

// File: rtl/dmcd_regs.sv
module dmcd_regs
  import dmcd_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output cfg_t              cfg
);
  localparam logic [REG_W-1:0]  FMASK = REG_W'((1 << FLD_W) - 1);
  localparam logic [REG_W-1:0]  MASK0 = (FMASK << N1_LSB) | (FMASK << N2_LSB) |
                                        (REG_W'(1) << DUAL_BIT) |
                                        (REG_W'(1) << OGATE_BIT) |
                                        (REG_W'(1) << IGATE_BIT);
  localparam logic [REG_W-1:0]  MASK1 = (FMASK << M1_LSB) | (FMASK << M2_LSB) |
                                        (REG_W'(1) << BYP_BIT);
  localparam logic [ADDR_W-1:0] A0    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A1    = ADDR_W'(1);

  logic [REG_W-1:0] w0_q, w1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w0_q  <= '0;
      w1_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && addr == A0) w0_q <= wdata & MASK0;
      if (wr_en && addr == A1) w1_q <= wdata & MASK1;
      if (addr == A0)      rdata <= w0_q;
      else if (addr == A1) rdata <= w1_q;
      else                 rdata <= '0;
    end
  end

  always_comb begin
    cfg.n1     = w0_q[N1_LSB +: FLD_W];
    cfg.n2     = w0_q[N2_LSB +: FLD_W];
    cfg.dual   = w0_q[DUAL_BIT];
    cfg.ogate  = w0_q[OGATE_BIT];
    cfg.igate  = w0_q[IGATE_BIT];
    cfg.m1     = w1_q[M1_LSB +: FLD_W];
    cfg.m2     = w1_q[M2_LSB +: FLD_W];
    cfg.bypass = w1_q[BYP_BIT];
  end
endmodule

// File: rtl/dmcd_core.sv
module dmcd_core
  import dmcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [FLD_W-1:0] n1,
  input  logic [FLD_W-1:0] n2,
  input  logic [FLD_W-1:0] m1,
  input  logic [FLD_W-1:0] m2,
  input  logic             dual,
  output logic [FLD_W-1:0] cnt_o,
  output logic [FLD_W-1:0] rep_o,
  output logic [FLD_W-1:0] cur_n_o,
  output logic [FLD_W-1:0] sh_n1_o,
  output logic             seg_o,
  output logic             sh_dual_o,
  output logic             at_start_o,
  output logic             in_high_o,
  output logic             period_end_o
);
  logic [FLD_W-1:0] cnt_q, rep_q;
  logic             seg_q;
  shadow_t          sh_q, fresh;
  logic [FLD_W-1:0] cur_n, cur_m;
  logic [FLD_W:0]   half;
  logic             last, seg_end, nxt_seg;

  always_comb begin
    fresh.n1   = n1;
    fresh.n2   = n2;
    fresh.m1   = m1;
    fresh.m2   = m2;
    fresh.dual = dual;
  end

  assign cur_n   = seg_q ? sh_q.n2 : sh_q.n1;
  assign cur_m   = seg_q ? sh_q.m2 : sh_q.m1;
  assign last    = (cnt_q == cur_n);
  assign seg_end = last && (!sh_q.dual || rep_q == cur_m);
  assign nxt_seg = sh_q.dual & ~seg_q;
  // period length is cur_n+1; high phase covers floor of half of it
  assign half    = ({1'b0, cur_n} + {{FLD_W{1'b0}}, 1'b1}) >> 1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      rep_q <= '0;
      seg_q <= 1'b0;
      sh_q  <= fresh;
    end else if (last) begin
      cnt_q <= '0;
      if (seg_end) begin
        rep_q <= '0;
        seg_q <= nxt_seg;
        if (!nxt_seg) sh_q <= fresh;
      end else begin
        rep_q <= rep_q + FLD_W'(1);
      end
    end else begin
      cnt_q <= cnt_q + FLD_W'(1);
    end
  end

  assign cnt_o        = cnt_q;
  assign rep_o        = rep_q;
  assign cur_n_o      = cur_n;
  assign sh_n1_o      = sh_q.n1;
  assign seg_o        = seg_q;
  assign sh_dual_o    = sh_q.dual;
  assign at_start_o   = (cnt_q == '0);
  assign in_high_o    = ({1'b0, cnt_q} < half);
  assign period_end_o = last | ~run;
endmodule

// File: rtl/dmcd_outstage.sv
module dmcd_outstage (
  input  logic clk,
  input  logic rst,
  input  logic igate,
  input  logic ogate,
  input  logic bypass,
  input  logic period_end,
  input  logic at_start,
  input  logic in_high,
  output logic ce_o,
  output logic div_o,
  output logic ogate_eff_o
);
  logic eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q <= 1'b0;
      ce_o  <= 1'b0;
      div_o <= 1'b0;
    end else begin
      if (!igate || bypass || period_end) eff_q <= ogate;
      ce_o  <= igate & eff_q & (bypass | at_start);
      div_o <= igate & eff_q & ~bypass & in_high;
    end
  end

  assign ogate_eff_o = eff_q;
endmodule

// File: rtl/dmcd_top.sv
module dmcd_top
  import dmcd_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              ce_out,
  output logic              div_out
);
  cfg_t             cfg;
  logic [FLD_W-1:0] core_cnt, core_rep, cur_n, sh_n1;
  logic             core_seg, sh_dual, at_start, in_high, period_end, ogate_eff;

  dmcd_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg(cfg)
  );

  dmcd_core u_core (
    .clk(clk), .rst(rst), .run(cfg.igate & ~cfg.bypass),
    .n1(cfg.n1), .n2(cfg.n2), .m1(cfg.m1), .m2(cfg.m2), .dual(cfg.dual),
    .cnt_o(core_cnt), .rep_o(core_rep), .cur_n_o(cur_n), .sh_n1_o(sh_n1),
    .seg_o(core_seg), .sh_dual_o(sh_dual), .at_start_o(at_start),
    .in_high_o(in_high), .period_end_o(period_end)
  );

  dmcd_outstage u_out (
    .clk(clk), .rst(rst), .igate(cfg.igate), .ogate(cfg.ogate),
    .bypass(cfg.bypass), .period_end(period_end), .at_start(at_start),
    .in_high(in_high), .ce_o(ce_out), .div_o(div_out), .ogate_eff_o(ogate_eff)
  );
endmodule

// File: rtl/dmcd_chk.sv
module dmcd_chk
  import dmcd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             igate,
  input logic             bypass,
  input logic             ogate_eff,
  input logic             ce_out,
  input logic             div_out,
  input logic [FLD_W-1:0] cnt,
  input logic [FLD_W-1:0] rep,
  input logic [FLD_W-1:0] cur_n,
  input logic [FLD_W-1:0] sh_n1,
  input logic             seg,
  input logic             sh_dual
);
  // R4: the period counter never runs past the active divisor
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= cur_n);

  // R6: without dual mode the second segment is never entered
  p_single_seg_r6: assert property (@(posedge clk) disable iff (rst)
    !sh_dual |-> !seg);

  // R7: bypass with gates open pulses every cycle, level held low
  p_bypass_every_r7: assert property (@(posedge clk) disable iff (rst)
    $past(bypass && igate && ogate_eff) |-> (ce_out && !div_out));

  // R8: run gate closed means silent outputs
  p_idle_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!igate) |-> (!ce_out && !div_out));

  // R10: active settings move only when a fresh N1 segment begins
  p_load_at_seg_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sh_n1) |-> (cnt == '0 && rep == '0 && !seg));
endmodule

bind dmcd_top dmcd_chk u_chk (
  .clk(clk), .rst(rst), .igate(cfg.igate), .bypass(cfg.bypass),
  .ogate_eff(ogate_eff), .ce_out(ce_out), .div_out(div_out),
  .cnt(core_cnt), .rep(core_rep), .cur_n(cur_n), .sh_n1(sh_n1),
  .seg(core_seg), .sh_dual(sh_dual)
);

// File: tb/dmcd_top_test.sv
module dmcd_top_test;
  localparam int CLK_P = 10;
  localparam int WD    = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [0:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ce_out, div_out;

  int    errs = 0;
  int    nchk = 0;
  int    plen [64];
  int    phi  [64];
  int    pre_hi;
  longint cyc = 0;

  dmcd_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ce_out(ce_out), .div_out(div_out)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk0(int n1f, int n2f, bit dual, bit og, bit ig);
    logic [31:0] v = '0;
    v[11:0]  = n1f[11:0];
    v[23:12] = n2f[11:0];
    v[28]    = dual;
    v[30]    = og;
    v[31]    = ig;
    return v;
  endfunction

  function automatic logic [31:0] mk1(int m1f, int m2f, bit byp);
    logic [31:0] v = '0;
    v[11:0]  = m1f[11:0];
    v[23:12] = m2f[11:0];
    v[24]    = byp;
    return v;
  endfunction

  function automatic int exp_len(int k, int n1f, int n2f, int m1f, int m2f, bit dual);
    int pos;
    if (!dual) return n1f + 1;
    pos = k % (m1f + m2f + 2);
    return (pos < m1f + 1) ? n1f + 1 : n2f + 1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_ce();
    int t = 0;
    pre_hi = 0;
    while (!ce_out && t < 20000) begin
      pre_hi += int'(div_out);
      @(negedge clk);
      t++;
    end
  endtask

  task automatic measure(int np);
    wait_ce();
    for (int i = 0; i < np; i++) begin
      int len = 0;
      int hi = 0;
      do begin
        len++;
        hi += int'(div_out);
        @(negedge clk);
      end while (!ce_out && len < 20000);
      plen[i] = len;
      phi[i]  = hi;
    end
  endtask

  task automatic restart(input logic [31:0] r0, input logic [31:0] r1);
    wr(1'b1, r1);
    wr(1'b0, (r0 & 32'h7FFF_FFFF) | 32'h4000_0000);
    wr(1'b0, r0 | 32'hC000_0000);
  endtask

  task automatic pattern_chk(string tag, int n1f, int n2f, int m1f, int m2f, bit dual, int np);
    int mism = 0;
    int fa = 0;
    int fe = 0;
    measure(np);
    for (int i = 0; i < np; i++) begin
      int el = exp_len(i, n1f, n2f, m1f, m2f, dual);
      if (plen[i] != el || phi[i] != el / 2) begin
        if (mism == 0) begin
          fa = (plen[i] != el) ? plen[i] : phi[i];
          fe = (plen[i] != el) ? el : el / 2;
        end
        mism++;
      end
    end
    chk(mism == 0, tag, fa, fe);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          cnt_ce, cnt_div, sum, n733;
    longint      t0;
    bit          ok;
    void'($urandom(32'd20240517));

    tick(5);
    rst = 1'b0;
    // R2: reset state
    chk(!ce_out && !div_out, "R2 outputs after reset", {ce_out, div_out}, 0);
    rd(1'b0, v); chk(v == 32'h0, "R2 word0 reset", v, 0);
    rd(1'b1, v); chk(v == 32'h0, "R2 word1 reset", v, 0);

    // R1: write, read back, reserved bits zero
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk(v == 32'hD0FF_FFFF, "R1 word0 mask", v, 32'hD0FF_FFFF);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); chk(v == 32'h01FF_FFFF, "R1 word1 mask", v, 32'h01FF_FFFF);
    wr(1'b0, 32'h1234_5678);
    rd(1'b0, v); chk(v == (32'h1234_5678 & 32'hD0FF_FFFF), "R1 word0 value", v, 32'h1234_5678 & 32'hD0FF_FFFF);
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0);

    // R3 R4 R5: single mode, even / odd / unit divisors
    restart(mk0(9, 0, 0, 0, 0), mk1(0, 0, 0));
    pattern_chk("R4 single div 10", 9, 0, 0, 0, 0, 4);
    restart(mk0(6, 0, 0, 0, 0), mk1(2, 0, 0));
    pattern_chk("R5 single odd div 7", 6, 0, 2, 0, 0, 4);
    restart(mk0(0, 0, 0, 0, 0), mk1(0, 0, 0));
    pattern_chk("R5 div 1 never high", 0, 0, 0, 0, 0, 4);

    // R6: fractional example, one full 19-period pattern
    restart(mk0(732, 731, 1, 0, 0), mk1(7, 10, 0));
    measure(19);
    sum = 0; n733 = 0;
    for (int i = 0; i < 19; i++) begin
      sum += plen[i];
      if (plen[i] == 733 && i < 8) n733++;
    end
    chk(sum == 13916, "R6 pattern total cycles", sum, 13916);
    chk(n733 == 8, "R6 leading N1 periods", n733, 8);
    chk(plen[8] == 732 && plen[18] == 732, "R6 N2 segment length", plen[18], 732);

    // R6 R5: random small configurations
    for (int it = 0; it < 8; it++) begin
      int  a  = int'($urandom_range(20, 0));
      int  b  = int'($urandom_range(20, 0));
      int  c  = int'($urandom_range(3, 0));
      int  d  = int'($urandom_range(3, 0));
      bit  du = bit'($urandom_range(1, 0));
      int  np = du ? 2 * (c + d + 2) : 4;
      restart(mk0(a, b, du, 0, 0), mk1(c, d, 0));
      pattern_chk("R6 random pattern", a, b, c, d, du, np);
    end

    // R8: drop run gate inside the N2 segment, then restart
    restart(mk0(3, 5, 1, 0, 0), mk1(1, 1, 0));
    measure(3);
    wr(1'b0, mk0(3, 5, 1, 1, 0));
    tick(2);
    cnt_ce = 0; cnt_div = 0;
    for (int i = 0; i < 30; i++) begin
      cnt_ce += int'(ce_out); cnt_div += int'(div_out); tick(1);
    end
    chk(cnt_ce == 0 && cnt_div == 0, "R8 silent while run gate clear", cnt_ce + cnt_div, 0);
    wr(1'b0, mk0(3, 5, 1, 1, 1));
    measure(3);
    chk(plen[0] == 4 && plen[1] == 4 && plen[2] == 6, "R8 restart at N1 segment", plen[2] * 100 + plen[0], 604);

    // R9: output gate
    wr(1'b1, mk1(0, 0, 0));
    wr(1'b0, mk0(15, 0, 0, 0, 0));
    wr(1'b0, mk0(15, 0, 0, 0, 1));
    tick(2);
    cnt_ce = 0; cnt_div = 0;
    for (int i = 0; i < 40; i++) begin
      cnt_ce += int'(ce_out); cnt_div += int'(div_out); tick(1);
    end
    chk(cnt_ce == 0 && cnt_div == 0, "R9 output gate closed", cnt_ce + cnt_div, 0);
    tick(5);
    wr(1'b0, mk0(15, 0, 0, 1, 1));
    measure(2);
    chk(pre_hi == 0, "R9 no partial period on open", pre_hi, 0);
    chk(plen[0] == 16 && phi[0] == 8, "R9 first full period", plen[0], 16);
    tick(3);
    wr(1'b0, mk0(15, 0, 0, 0, 1));
    cnt_ce = 0;
    for (int i = 0; i < 64; i++) begin
      cnt_ce += int'(ce_out); tick(1);
    end
    chk(cnt_ce == 0, "R9 close at boundary", cnt_ce, 0);

    // R10: single mode divisor change mid-period
    restart(mk0(7, 0, 0, 0, 0), mk1(0, 0, 0));
    wait_ce();
    t0 = cyc;
    wr(1'b0, mk0(11, 0, 0, 1, 1));
    wait_ce();
    chk(cyc - t0 == 8, "R10 period not truncated", cyc - t0, 8);
    measure(1);
    chk(plen[0] == 12, "R10 new divisor next period", plen[0], 12);

    // R10: dual mode change waits for next N1 segment
    restart(mk0(3, 5, 1, 0, 0), mk1(1, 1, 0));
    wait_ce();
    t0 = cyc;
    wr(1'b0, mk0(9, 5, 1, 1, 1));
    wait_ce();
    chk(cyc - t0 == 4, "R10 dual first period old", cyc - t0, 4);
    measure(4);
    chk(plen[0] == 4 && plen[1] == 6 && plen[2] == 6, "R10 pattern finishes old", plen[0] * 100 + plen[1] * 10 + plen[2], 466);
    chk(plen[3] == 10, "R10 new N1 at segment start", plen[3], 10);

    // R7: bypass ignores divisors
    wr(1'b1, mk1(1, 1, 1));
    tick(2);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (!ce_out || div_out) ok = 1'b0;
      tick(1);
    end
    chk(ok, "R7 bypass pulses every cycle", ok, 1);
    wr(1'b1, mk1(1, 1, 0));

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule